// File: doc/BRIEF.md
# Serial Receive FIFO Interrupt Unit

This block is the receive-side word store and interrupt logic for a two-channel synchronous serial audio port. The deserializer hands it one word at a time per channel through a valid strobe. Each channel keeps its words either in an eight-entry first-in first-out store or, when the store is switched to single mode, in one holding slot. A read strobe from the host register interface removes the oldest word of that channel. The read data port always shows the oldest stored word, already aligned and extended to the bus width.

Per channel the unit reports a data-ready flag, a full flag and a sticky overrun flag. It also drives two interrupt requests: one used when an overrun is pending ("exception") and one used when it is not ("normal"). In store mode the interrupt source is the full flag. In single mode it is the ready flag. A global interrupt enable masks both requests without touching the flags. Dropping the receiver enable empties both channels. Turning two-channel mode off empties channel 1 and holds it idle.

Top module: `sai_rx_irq_unit`

## Requirements
- R1: After reset, every ready, full, overrun and interrupt output of both channels is 0.
- R2: With MSB alignment off, the read word holds the low L bits of the received word at the bottom of the bus. L is 8, 16, 24 or 32 for length code 0, 1, 2 or 3. Received bits above L are ignored. The bits above L are 0 when sign extension is off, and copies of bit L-1 when it is on.
- R3: With the MSB-alignment input at 1 and the fixed-protocol input at 0, the low L bits move to the top L bits of the bus and the lower bits are 0. With the fixed-protocol input at 1, R2's LSB placement is used whatever the MSB-alignment input is.
- R4: In store mode a channel keeps up to 8 words, read back oldest first. Ready is 1 while at least one word is held. Full is 1 when 8 words are held.
- R5: In single mode a channel keeps one word, and both ready and full are 1 while that word is held.
- R6: A read strobe while ready is 1 removes the oldest word on that clock edge. The read data port then shows the next word, or ready falls to 0.
- R7: A word that arrives while the channel is full, with no read on the same edge, is discarded and sets overrun. Overrun stays at 1 until an overrun-clear strobe for that channel.
- R8: The interrupt source of a channel is its full flag in store mode and its ready flag in single mode.
- R9: While the source is 1 and interrupts are enabled, the exception request is 1 if overrun is 1 and the normal request is 1 if overrun is 0. Otherwise both requests are 0.
- R10: With the interrupt enable at 0, both requests of both channels are 0, while ready, full and overrun keep updating.
- R11: With two-channel mode off, channel 1 stores nothing, and all its flags and requests read 0. Words it held are discarded.
- R12: With the receiver enable at 0, incoming words are ignored and both channels are emptied, with overrun cleared. Stored words do not come back when it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 empties both channels |
| irq_en | input | 1 | Receive interrupt enable |
| fifo_en | input | 1 | 1 = 8-entry store mode, 0 = single-slot mode |
| dual_ch | input | 1 | Two-channel mode enable |
| sign_ext | input | 1 | 1 = sign extension, 0 = zero extension |
| msb_align | input | 1 | Place word at top of bus (ignored when proto_fixed = 1) |
| proto_fixed | input | 1 | Fixed-format protocol active; forces LSB placement |
| wlen | input | 2 | Word length code: 0=8, 1=16, 2=24, 3=32 bits |
| rx_valid | input | 2 | Per-channel word strobe from the deserializer |
| rx_data0 | input | BUS_W | Channel 0 received word |
| rx_data1 | input | BUS_W | Channel 1 received word |
| rd_strobe | input | 2 | Per-channel read of the data register |
| ovr_clr | input | 2 | Per-channel write-one clear of overrun |
| rd_data0 | output | BUS_W | Channel 0 oldest word, formatted |
| rd_data1 | output | BUS_W | Channel 1 oldest word, formatted |
| ready | output | 2 | Per-channel data-ready flag |
| full | output | 2 | Per-channel full flag |
| ovr | output | 2 | Per-channel sticky overrun flag |
| irq_exc | output | 2 | Per-channel interrupt with exception status |
| irq_norm | output | 2 | Per-channel interrupt without exception |

## Verification
A wrong occupancy count shows up at the ports within one clock edge of the push or read that caused it. Full rises on the wrong word, ready stays up after the last read, or a word is duplicated or skipped in the read order. A lost or stuck overrun bit moves the request from the normal line to the exception line on the same cycle as the flag. A pointer error shows only when a word is read back, which is why every stored word is read and compared. Flush faults tied to the receiver enable or two-channel mode appear when the mode comes back: ready must stay at 0.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

    typedef enum logic [1:0] {
        WLEN_8  = 2'd0,
        WLEN_16 = 2'd1,
        WLEN_24 = 2'd2,
        WLEN_32 = 2'd3
    } wlen_e;

    typedef struct packed {
        logic  sign_ext;
        logic  msb_align;
        logic  proto_fixed;
        wlen_e wlen;
    } fmt_cfg_t;

    typedef struct packed {
        logic ready;
        logic full;
        logic ovr;
    } ch_flags_t;

    typedef struct packed {
        logic exc;
        logic norm;
    } ch_irq_t;

    function automatic int wlen_bits(wlen_e l);
        case (l)
            WLEN_8:  return 8;
            WLEN_16: return 16;
            WLEN_24: return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/sai_rx_align.sv
module sai_rx_align
    import sai_rx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] raw,
    input  fmt_cfg_t     cfg,
    output logic [W-1:0] word
);
    int  nb;
    int  idx;
    logic to_top;

    always_comb begin
        nb = wlen_bits(cfg.wlen);
        if (nb > W) nb = W;
        to_top = cfg.msb_align & ~cfg.proto_fixed;
        idx = 0;
        for (int i = 0; i < W; i++) begin
            if (to_top) begin
                idx = i - (W - nb);
                word[i] = (idx >= 0) ? raw[idx] : 1'b0;
            end else begin
                word[i] = (i < nb) ? raw[i] : (cfg.sign_ext & raw[nb-1]);
            end
        end
    end
endmodule

// File: rtl/sai_rx_store.sv
module sai_rx_store #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         fifo_mode,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         ovr_clr,
    output logic [W-1:0] head,
    output logic         ready,
    output logic         full,
    output logic         ovr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt, cap;
    logic          do_pop, do_push, drop, space;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign do_pop  = en & pop & (cnt != '0);
    assign space   = (cnt < cap) | do_pop;
    assign do_push = en & push & space;
    assign drop    = en & push & ~space;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            rp  <= '0;
            wp  <= '0;
            ovr <= 1'b0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
            if (drop)         ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && do_push) mem[wp] <= din;
    end

    assign head  = mem[rp];
    assign ready = (cnt != '0);
    assign full  = (cnt >= cap);

    // R7: a dropped word leaves occupancy unchanged and raises overrun
    a_r7_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        drop |=> ($stable(cnt) && ovr));
    // R7: overrun is sticky until cleared
    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr && en) |=> ovr);
    // R6: a read without a write lowers occupancy by one
    a_r6_pop_count: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !do_push) |=> (cnt == $past(cnt) - 1'b1));
    // R12: disabling the channel empties it
    a_r12_flush: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ready && !ovr));
    // R4: occupancy never passes the store depth
    a_r4_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/sai_rx_irq.sv
module sai_rx_irq
    import sai_rx_pkg::*;
(
    input  logic      irq_en,
    input  logic      fifo_mode,
    input  ch_flags_t flags,
    output ch_irq_t   req
);
    logic src;

    assign src      = fifo_mode ? flags.full : flags.ready;
    assign req.exc  = irq_en & src & flags.ovr;
    assign req.norm = irq_en & src & ~flags.ovr;
endmodule

// File: rtl/sai_rx_irq_unit.sv
module sai_rx_irq_unit
    import sai_rx_pkg::*;
#(
    parameter int BUS_W      = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             irq_en,
    input  logic             fifo_en,
    input  logic             dual_ch,
    input  logic             sign_ext,
    input  logic             msb_align,
    input  logic             proto_fixed,
    input  logic [1:0]       wlen,
    input  logic [1:0]       rx_valid,
    input  logic [BUS_W-1:0] rx_data0,
    input  logic [BUS_W-1:0] rx_data1,
    input  logic [1:0]       rd_strobe,
    input  logic [1:0]       ovr_clr,
    output logic [BUS_W-1:0] rd_data0,
    output logic [BUS_W-1:0] rd_data1,
    output logic [1:0]       ready,
    output logic [1:0]       full,
    output logic [1:0]       ovr,
    output logic [1:0]       irq_exc,
    output logic [1:0]       irq_norm
);
    localparam int NUM_CH = 2;

    fmt_cfg_t         cfg;
    logic [BUS_W-1:0] din  [NUM_CH];
    logic [BUS_W-1:0] dout [NUM_CH];

    assign cfg.sign_ext    = sign_ext;
    assign cfg.msb_align   = msb_align;
    assign cfg.proto_fixed = proto_fixed;
    assign cfg.wlen        = wlen_e'(wlen);

    assign din[0]   = rx_data0;
    assign din[1]   = rx_data1;
    assign rd_data0 = dout[0];
    assign rd_data1 = dout[1];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             ch_on;
        logic [BUS_W-1:0] head;
        ch_flags_t        st, fl;
        ch_irq_t          req;

        assign ch_on = rx_en & ((c == 0) | dual_ch);

        sai_rx_store #(.W(BUS_W), .DEPTH(FIFO_DEPTH)) u_store (
            .clk       (clk),
            .rst       (rst),
            .en        (ch_on),
            .fifo_mode (fifo_en),
            .push      (rx_valid[c]),
            .din       (din[c]),
            .pop       (rd_strobe[c]),
            .ovr_clr   (ovr_clr[c]),
            .head      (head),
            .ready     (st.ready),
            .full      (st.full),
            .ovr       (st.ovr)
        );

        assign fl.ready = st.ready & ch_on;
        assign fl.full  = st.full  & ch_on;
        assign fl.ovr   = st.ovr   & ch_on;

        sai_rx_align #(.W(BUS_W)) u_align (
            .raw  (head),
            .cfg  (cfg),
            .word (dout[c])
        );

        sai_rx_irq u_irq (
            .irq_en    (irq_en),
            .fifo_mode (fifo_en),
            .flags     (fl),
            .req       (req)
        );

        assign ready[c]    = fl.ready;
        assign full[c]     = fl.full;
        assign ovr[c]      = fl.ovr;
        assign irq_exc[c]  = req.exc;
        assign irq_norm[c] = req.norm;

        // R10: a cleared enable masks both requests
        a_r10_mask: assert property (@(posedge clk) disable iff (rst)
            !irq_en |-> !(irq_exc[c] || irq_norm[c]));
        // R8: in single mode a ready word with the enable set raises a request
        a_r8_single_src: assert property (@(posedge clk) disable iff (rst)
            (irq_en && !fifo_en && ready[c]) |-> (irq_exc[c] || irq_norm[c]));
        // R9: a pending overrun never drives the normal request
        a_r9_split: assert property (@(posedge clk) disable iff (rst)
            ovr[c] |-> !irq_norm[c]);
    end

    // R11: with two-channel mode off, channel 1 stays idle
    a_r11_ch1_idle: assert property (@(posedge clk) disable iff (rst)
        !dual_ch |-> (ready[1] == 1'b0 && ovr[1] == 1'b0 && irq_exc[1] == 1'b0));
endmodule

// File: tb/sai_rx_irq_unit_test.sv
module sai_rx_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b1, irq_en = 1'b1, fifo_en = 1'b0, dual_ch = 1'b1;
    logic        sign_ext = 1'b0, msb_align = 1'b0, proto_fixed = 1'b0;
    logic [1:0]  wlen = 2'd3;
    logic [1:0]  rx_valid = '0, rd_strobe = '0, ovr_clr = '0;
    logic [31:0] rx_data0 = '0, rx_data1 = '0;
    logic [31:0] rd_data0, rd_data1;
    logic [1:0]  ready, full, ovr, irq_exc, irq_norm;

    int checks = 0;
    int errors = 0;
    logic [31:0] q0[$];
    logic [31:0] q1[$];

    always #2 clk = ~clk;

    sai_rx_irq_unit uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .irq_en(irq_en), .fifo_en(fifo_en),
        .dual_ch(dual_ch), .sign_ext(sign_ext), .msb_align(msb_align),
        .proto_fixed(proto_fixed), .wlen(wlen), .rx_valid(rx_valid),
        .rx_data0(rx_data0), .rx_data1(rx_data1), .rd_strobe(rd_strobe),
        .ovr_clr(ovr_clr), .rd_data0(rd_data0), .rd_data1(rd_data1),
        .ready(ready), .full(full), .ovr(ovr), .irq_exc(irq_exc), .irq_norm(irq_norm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] d);
        int nb;
        logic [31:0] r;
        nb = (wlen == 2'd0) ? 8 : (wlen == 2'd1) ? 16 : (wlen == 2'd2) ? 24 : 32;
        r = '0;
        if (msb_align && !proto_fixed) begin
            for (int k = 0; k < nb; k++) r[32 - nb + k] = d[k];
        end else begin
            for (int k = 0; k < 32; k++)
                r[k] = (k < nb) ? d[k] : (sign_ext ? d[nb-1] : 1'b0);
        end
        return r;
    endfunction

    // driver: present one word, queue it when it is expected to be stored
    task automatic push(input int ch, input logic [31:0] d, input bit keep);
        @(negedge clk);
        rx_valid[ch] = 1'b1;
        if (ch == 0) rx_data0 = d; else rx_data1 = d;
        @(negedge clk);
        rx_valid[ch] = 1'b0;
        if (keep) begin
            if (ch == 0) q0.push_back(d); else q1.push_back(d);
        end
    endtask

    // monitor: compare the oldest word with the scoreboard, then read it out
    task automatic pull(input int ch, input string tag);
        logic [31:0] exp_raw;
        logic [31:0] act;
        if (ch == 0) begin
            exp_raw = q0.pop_front();
            act = rd_data0;
        end else begin
            exp_raw = q1.pop_front();
            act = rd_data1;
        end
        chk(tag, act, model(exp_raw));
        rd_strobe[ch] = 1'b1;
        @(negedge clk);
        rd_strobe[ch] = 1'b0;
    endtask

    task automatic clear_ovr(input int ch);
        ovr_clr[ch] = 1'b1;
        @(negedge clk);
        ovr_clr[ch] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 flags", {22'b0, ready, full, ovr, irq_exc, irq_norm}, 32'h0);

        // R5 R8 R9 single mode, normal request
        push(0, 32'h1234_5678, 1);
        chk("R5 ready", ready[0], 1'b1);
        chk("R5 full", full[0], 1'b1);
        chk("R9 norm", irq_norm[0], 1'b1);
        chk("R9 exc", irq_exc[0], 1'b0);
        pull(0, "R6 data");
        chk("R6 ready low", ready[0], 1'b0);
        chk("R8 no req", irq_norm[0], 1'b0);

        // R2 extension for 8/16/24 bits
        for (int w = 0; w < 3; w++) begin
            for (int s = 0; s < 2; s++) begin
                wlen = 2'(w);
                sign_ext = 1'(s);
                push(0, 32'hF1A5_9CE3, 1);
                pull(0, "R2 neg word");
                push(0, 32'hFF35_6A2B, 1);
                pull(0, "R2 pos word");
            end
        end

        // R3 alignment
        wlen = 2'd1; sign_ext = 1'b1; msb_align = 1'b1; proto_fixed = 1'b0;
        push(0, 32'hABCD_1234, 1);
        pull(0, "R3 msb placement");
        proto_fixed = 1'b1;
        push(0, 32'h0000_9234, 1);
        pull(0, "R3 forced lsb");
        msb_align = 1'b0; proto_fixed = 1'b0; sign_ext = 1'b0; wlen = 2'd3;

        // R7 overrun in single mode
        push(0, 32'hAAAA_0001, 1);
        push(0, 32'hBBBB_0002, 0);
        chk("R7 ovr set", ovr[0], 1'b1);
        chk("R9 exc req", irq_exc[0], 1'b1);
        chk("R9 no norm", irq_norm[0], 1'b0);
        pull(0, "R7 first kept");
        chk("R7 empty after drop", ready[0], 1'b0);
        chk("R7 sticky", ovr[0], 1'b1);
        clear_ovr(0);
        chk("R7 cleared", ovr[0], 1'b0);

        // R4 R8 store mode
        fifo_en = 1'b1;
        for (int i = 0; i < 7; i++) push(0, 32'h100 + 32'(i), 1);
        chk("R4 ready", ready[0], 1'b1);
        chk("R4 not full", full[0], 1'b0);
        chk("R8 no req at 7", {irq_exc[0], irq_norm[0]}, 32'h0);
        push(0, 32'h107, 1);
        chk("R4 full", full[0], 1'b1);
        chk("R8 norm when full", irq_norm[0], 1'b1);
        push(0, 32'h1FF, 0);
        chk("R7 store ovr", ovr[0], 1'b1);
        chk("R9 store exc", {irq_exc[0], irq_norm[0]}, 32'h2);
        for (int i = 0; i < 8; i++) pull(0, "R4 order");
        chk("R4 drained", ready[0], 1'b0);
        clear_ovr(0);
        fifo_en = 1'b0;

        // R10 mask
        irq_en = 1'b0;
        push(0, 32'h0000_0C0C, 1);
        chk("R10 ready still", ready[0], 1'b1);
        chk("R10 masked", {irq_exc[0], irq_norm[0]}, 32'h0);
        pull(0, "R10 data");
        irq_en = 1'b1;

        // R11 two-channel mode
        push(1, 32'h0000_5555, 1);
        chk("R11 ch1 ready", ready[1], 1'b1);
        chk("R11 ch1 req", irq_norm[1], 1'b1);
        pull(1, "R11 ch1 data");
        push(1, 32'h0000_6666, 0);
        dual_ch = 1'b0;
        @(negedge clk);
        chk("R11 ch1 idle", {ready[1], irq_norm[1]}, 32'h0);
        push(1, 32'h0000_7777, 0);
        chk("R11 ch1 ignores", ready[1], 1'b0);
        dual_ch = 1'b1;
        @(negedge clk);
        chk("R11 ch1 flushed", ready[1], 1'b0);

        // R12 receiver disable
        push(0, 32'h0000_8888, 0);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R12 emptied", ready[0], 1'b0);
        push(0, 32'h0000_9999, 0);
        chk("R12 ignores", ready[0], 1'b0);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R12 stays empty", ready[0], 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule